// File: doc/BRIEF.md
# Periodic Host Refresh Slot Generator

While a guest processor holds the shared bus, a dynamic host processor is parked off the bus. If it stays parked too long, its internal state decays. This block tracks how long the host has been continuously excluded. At a fixed interval it steals a short slot and gives the host one wait cycle. During that slot the guest's bus buffers are disabled, the DMA request is released, and the guest's cycle acknowledge is held off. After that the guest gets the bus back.

Slots are aligned to the start of a video phase. A phase start is a rising edge of `phi1`, taken one clock late through a register. Control returns to the guest on the first phase start after the slot ends. A hard limit on continuous exclusion forces a slot even when no phase start arrives. All timing is counted in reference-clock ticks. Parameters: `INTERVAL_TICKS` (slot request spacing), `SLOT_TICKS` (DMA release width) and `MAX_HOLD_TICKS` (hard limit, greater than `INTERVAL_TICKS`).

Top module: `refresh_slot_gen`

## Requirements
- R1: After reset all four outputs are low, and they remain low until a slot starts.
- R2: While `guest_owns` is low, no output is asserted and the exclusion count is cleared. After each takeover, the first slot therefore starts no earlier than `INTERVAL_TICKS` cycles later, even if phase starts occur before that.
- R3: Once the guest has held the bus for `INTERVAL_TICKS` cycles, the next slot starts at a phase start. `dma_release` first reads high in the cycle after the rising `phi1` is sampled.
- R4: `dma_release` stays high for exactly `SLOT_TICKS` consecutive cycles per slot while the guest keeps ownership.
- R5: `buf_disable` rises together with `dma_release` and stays high after the release ends. It falls in the cycle after the first `phi1` rise that is sampled once the release has ended.
- R6: `refresh_active`, `buf_disable` and `dtack_inhibit` are equal in every cycle, so the guest can never see an acknowledge while the window is open.
- R7: The number of continuous cycles with `guest_owns` high and `dma_release` low never exceeds `MAX_HOLD_TICKS`. When no phase start comes, a slot is forced after exactly that many cycles, and forced slots repeat every `MAX_HOLD_TICKS + SLOT_TICKS` cycles.
- R8: If `guest_owns` falls, all outputs are low from the next cycle on, including in the middle of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, all timing counted in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| guest_owns | input | 1 | High while the guest processor owns the shared bus |
| phi1 | input | 1 | Video phase indicator; a rising edge marks a phase start |
| refresh_active | output | 1 | High for the whole stolen window |
| buf_disable | output | 1 | Forces the guest address/data buffers off |
| dma_release | output | 1 | Releases the DMA request line high for the host |
| dtack_inhibit | output | 1 | Blocks the guest's cycle acknowledge |

## Verification
The exclusion counter and the slot sequencer fail in ways that are visible at the ports. A counter that does not clear on loss of ownership, or that counts from the wrong event, moves the first `dma_release` rise away from its exact expected cycle. Both the phase-aligned case and the forced case show this on the first slot after takeover. A sequencer stuck in the wrong state shows up within one slot: the release has the wrong width, the window does not close on the right phase start, or the three window outputs disagree. An exclusion stretch longer than the limit shows up as soon as that stretch passes `MAX_HOLD_TICKS` cycles.

// File: rtl/refslot_pkg.sv
package refslot_pkg;

    // Sequencer states of the refresh slot generator.
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,  // guest on the bus, counting exclusion time
        ST_ARMED  = 2'd1,  // interval reached, waiting for a phase start
        ST_SLOT   = 2'd2,  // DMA released, host runs its wait cycle
        ST_RETURN = 2'd3   // release over, hand back at next phase start
    } slot_state_e;

endpackage

// File: rtl/refslot_phase_edge.sv
module refslot_phase_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_in,
    output logic phase_rise
);

    logic seen_d, seen_q;

    always_comb begin
        seen_d = phase_in;
    end

    // Reset to one so a phase already high at reset release is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b1;
        else        seen_q <= seen_d;
    end

    assign phase_rise = phase_in & ~seen_q;

endmodule

// File: rtl/refslot_hold_timer.sv
module refslot_hold_timer #(
    parameter int INTERVAL_TICKS = 64,
    parameter int MAX_HOLD_TICKS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic interval_hit,
    output logic limit_hit
);

    localparam int CNT_W = $clog2(MAX_HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INTERVAL_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_LAST = CNT_W'(MAX_HOLD_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear)                cnt_d = '0;
        else if (cnt_q == LIM_LAST) cnt_d = cnt_q;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign interval_hit = !clear && (cnt_q >= INT_LAST);
    assign limit_hit    = !clear && (cnt_q == LIM_LAST);

endmodule

// File: rtl/refresh_slot_gen.sv
module refresh_slot_gen #(
    parameter int INTERVAL_TICKS = 64,
    parameter int SLOT_TICKS     = 4,
    parameter int MAX_HOLD_TICKS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic guest_owns,
    input  logic phi1,
    output logic refresh_active,
    output logic buf_disable,
    output logic dma_release,
    output logic dtack_inhibit
);

    import refslot_pkg::*;

    localparam int SLOT_W = $clog2(SLOT_TICKS + 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_TICKS - 1);

    typedef struct packed {
        slot_state_e       state;
        logic [SLOT_W-1:0] slot_cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic phase_rise;
    logic interval_hit;
    logic limit_hit;
    logic hold_clear;

    refslot_phase_edge i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_in  (phi1),
        .phase_rise(phase_rise)
    );

    // Exclusion time restarts whenever the host regains the bus.
    assign hold_clear = !guest_owns || (seq_q.state == ST_SLOT);

    refslot_hold_timer #(
        .INTERVAL_TICKS(INTERVAL_TICKS),
        .MAX_HOLD_TICKS(MAX_HOLD_TICKS)
    ) i_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (hold_clear),
        .interval_hit(interval_hit),
        .limit_hit   (limit_hit)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_RUN: begin
                if (limit_hit) begin
                    seq_d.state    = ST_SLOT;
                    seq_d.slot_cnt = '0;
                end else if (interval_hit) begin
                    seq_d.state = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (phase_rise || limit_hit) begin
                    seq_d.state    = ST_SLOT;
                    seq_d.slot_cnt = '0;
                end
            end
            ST_SLOT: begin
                if (seq_q.slot_cnt == SLOT_LAST) seq_d.state = ST_RETURN;
                else seq_d.slot_cnt = seq_q.slot_cnt + 1'b1;
            end
            ST_RETURN: begin
                if (phase_rise) begin
                    seq_d.state = ST_RUN;
                end else if (limit_hit) begin
                    seq_d.state    = ST_SLOT;
                    seq_d.slot_cnt = '0;
                end
            end
            default: seq_d.state = ST_RUN;
        endcase
        if (!guest_owns) begin
            seq_d.state    = ST_RUN;
            seq_d.slot_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state    <= ST_RUN;
            seq_q.slot_cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    logic window;
    assign window         = (seq_q.state == ST_SLOT) || (seq_q.state == ST_RETURN);
    assign refresh_active = window;
    assign buf_disable    = window;
    assign dtack_inhibit  = window;
    assign dma_release    = (seq_q.state == ST_SLOT);

endmodule

// File: rtl/refresh_slot_gen_chk.sv
module refresh_slot_gen_chk #(
    parameter int SLOT_TICKS     = 4,
    parameter int MAX_HOLD_TICKS = 80
) (
    input logic clk,
    input logic rst_n,
    input logic guest_owns,
    input logic phi1,
    input logic refresh_active,
    input logic buf_disable,
    input logic dma_release,
    input logic dtack_inhibit
);

    localparam int LOW_W = $clog2(MAX_HOLD_TICKS + 2);
    localparam int REL_W = $clog2(SLOT_TICKS + 2);

    logic [LOW_W-1:0] low_cnt;
    logic [REL_W-1:0] rel_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            rel_cnt <= '0;
        end else begin
            if (guest_owns && !dma_release) begin
                if (low_cnt != LOW_W'(MAX_HOLD_TICKS + 1)) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
            if (dma_release) begin
                if (rel_cnt != REL_W'(SLOT_TICKS + 1)) rel_cnt <= rel_cnt + 1'b1;
            end else begin
                rel_cnt <= '0;
            end
        end
    end

    // R6: the three window outputs agree in every cycle
    assert_window_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack_inhibit == refresh_active) && (buf_disable == refresh_active));

    // R5: the release lies inside the buffer-disable window
    assert_release_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_release |-> buf_disable);

    // R5: while ownership is kept, the window closes only after a phase start
    assert_phase_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(refresh_active) && $past(guest_owns)) |-> $past(phi1));

    // R8: loss of ownership clears the window next cycle
    assert_owner_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !guest_owns |=> !refresh_active);

    // R4: release never longer than the slot length
    assert_slot_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_cnt <= REL_W'(SLOT_TICKS));

    // R7: continuous exclusion bounded
    assert_hold_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= LOW_W'(MAX_HOLD_TICKS));

endmodule

bind refresh_slot_gen refresh_slot_gen_chk #(
    .SLOT_TICKS    (SLOT_TICKS),
    .MAX_HOLD_TICKS(MAX_HOLD_TICKS)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .guest_owns    (guest_owns),
    .phi1          (phi1),
    .refresh_active(refresh_active),
    .buf_disable   (buf_disable),
    .dma_release   (dma_release),
    .dtack_inhibit (dtack_inhibit)
);

// File: tb/test_refresh_slot_gen.sv
module test_refresh_slot_gen;

    localparam int INTERVAL = 64;
    localparam int SLOT     = 4;
    localparam int MAXH     = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic guest_owns = 1'b0;
    logic phi1 = 1'b0;
    logic refresh_active, buf_disable, dma_release, dtack_inhibit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int low_run = 0;
    int max_low = 0;
    int disagree = 0;
    bit rel_a [0:255];
    bit win_a [0:255];

    always #5 clk = ~clk;

    refresh_slot_gen #(
        .INTERVAL_TICKS(INTERVAL),
        .SLOT_TICKS    (SLOT),
        .MAX_HOLD_TICKS(MAXH)
    ) i_refresh_slot_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .guest_owns    (guest_owns),
        .phi1          (phi1),
        .refresh_active(refresh_active),
        .buf_disable   (buf_disable),
        .dma_release   (dma_release),
        .dtack_inhibit (dtack_inhibit)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs, then sample at the following falling edge.
    task automatic step(input logic o, input logic p);
        guest_owns = o;
        phi1 = p;
        @(negedge clk);
        if (o && !dma_release) low_run++;
        else low_run = 0;
        if (low_run > max_low) max_low = low_run;
        if ((buf_disable != refresh_active) || (dtack_inhibit != refresh_active)) disagree++;
    endtask

    // Index of the first phase rise at or after 'from' (phi1 = ((i+1)/4)%2).
    function automatic int next_rise(input int from);
        for (int i = from; i < 100000; i++) if (((i + 1) % 8) == 4) return i;
        return -1;
    endfunction

    function automatic int first_set(input bit arr [0:255], input int from);
        for (int i = from; i < 256; i++) if (arr[i]) return i;
        return -1;
    endfunction

    function automatic int first_clear(input bit arr [0:255], input int from);
        for (int i = from; i < 256; i++) if (!arr[i]) return i;
        return -1;
    endfunction

    // Take the bus at index 0 and record n samples; mode 0 toggles phi1, mode 1 holds it low.
    task automatic record(input int n, input int mode);
        for (int k = 0; k < 256; k++) begin rel_a[k] = 1'b0; win_a[k] = 1'b0; end
        max_low = 0;
        low_run = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b1, (mode == 0) ? logic'(((i + 1) / 4) % 2) : 1'b0);
            rel_a[i + 1] = dma_release;
            win_a[i + 1] = refresh_active;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset refresh_active", int'(refresh_active), 0);
        check("R1 reset dma_release", int'(dma_release), 0);
        check("R1 reset buf_disable", int'(buf_disable), 0);
        check("R1 reset dtack_inhibit", int'(dtack_inhibit), 0);
        rst_n = 1'b1;
        idle(5);
        check("R1 outputs low after reset release", int'(refresh_active | dma_release), 0);
    endtask

    task automatic t_not_owner;
        int seen = 0;
        for (int i = 0; i < 200; i++) begin
            step(1'b0, logic'((i / 4) % 2));
            if (refresh_active || dma_release || buf_disable || dtack_inhibit) seen++;
        end
        check("R2 no output without ownership", seen, 0);
    endtask

    task automatic t_phase_aligned;
        int s1, r1, s2;
        idle(4);
        disagree = 0;
        record(200, 0);
        s1 = next_rise(INTERVAL) + 1;
        check("R2 R3 first release at first phase start after interval", first_set(rel_a, 1), s1);
        check("R4 release width first slot", first_clear(rel_a, s1) - s1, SLOT);
        check("R5 window opens with release", first_set(win_a, 1), s1);
        r1 = next_rise(s1 + SLOT);
        check("R5 window closes after phase start following release", first_clear(win_a, s1), r1 + 1);
        s2 = next_rise(s1 + SLOT + INTERVAL) + 1;
        check("R3 second slot at phase start", first_set(rel_a, s1 + SLOT), s2);
        check("R4 release width second slot", first_clear(rel_a, s2) - s2, SLOT);
        check("R6 window outputs agree", disagree, 0);
        check("R7 stretch within limit (aligned)", int'(max_low <= MAXH), 1);
    endtask

    task automatic t_forced;
        idle(4);
        disagree = 0;
        record(200, 1);
        check("R7 forced slot at hard limit", first_set(rel_a, 1), MAXH);
        check("R4 forced release width", first_clear(rel_a, MAXH) - MAXH, SLOT);
        check("R7 forced slot repeats", first_set(rel_a, MAXH + SLOT), MAXH + SLOT + MAXH);
        check("R5 window held without phase start", int'(win_a[100] && !rel_a[100]), 1);
        check("R7 stretch within limit (forced)", int'(max_low <= MAXH), 1);
        check("R6 window outputs agree (forced)", disagree, 0);
    endtask

    task automatic t_drop;
        idle(4);
        record(82, 1);
        check("R4 mid-slot before drop", int'(dma_release), 1);
        step(1'b0, 1'b0);
        check("R8 drop clears release", int'(dma_release), 0);
        check("R8 drop clears window", int'(refresh_active | buf_disable | dtack_inhibit), 0);
        idle(10);
        record(100, 1);
        check("R2 retake restarts full count", first_set(rel_a, 1), MAXH);
    endtask

    initial begin
        t_reset();
        t_not_owner();
        t_phase_aligned();
        t_forced();
        t_drop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule